// File: doc/BRIEF.md
# Serial EEPROM Boot Configuration Reader

This block fetches a small set of identity and configuration values from an external three-wire serial EEPROM once, right after system reset. Command and response share a single bidirectional data wire. The block drives a read command for word address zero onto that wire and then stops driving it. It discards the one filler bit that the memory returns and shifts in three consecutive 16-bit words. The memory advances its own address from one word to the next.

When the burst is over, the block stops driving both the serial clock and the data wire, so that other logic can use the same memory. The three words appear on parallel outputs together with a one-cycle completion pulse. Word 0 is a configuration word whose top bit selects ganged power handling. Word 1 is the vendor ID and word 2 is the product ID.

A strap input selects whether the memory is used at all. With the strap high the interface never becomes active, and the block reports built-in default values instead.

Top module: `mwr_boot_reader`

## Requirements
- R1: With `ext_rom_n` low at reset release, exactly one read runs. It lasts 58 serial clock periods and starts on the first clock edge after reset. `sck_oe` falls in the same cycle that `boot_done` rises, and no serial clock edge follows.
- R2: Each serial clock period lasts `CLK_DIV` system cycles. `sck_o` is low for the first `CLK_DIV/2` cycles of a period and high for the rest. `sck_oe` is high for the whole transfer, and `sck_o` is never high without it.
- R3: In periods 0 to 8, `sio_oe` is high and `sio_o` carries 1,1,0,0,0,0,0,0,0: the start bit, the read opcode 1 then 0, and six zero address bits. `sio_o` only changes while `sck_o` is low.
- R4: `sio_oe` falls at the start of period 9 and stays low. The block never drives the data wire while the memory does.
- R5: The bit sampled in period 9 is a filler bit and is discarded, whatever its value.
- R6: In periods 10 to 57, `sio_i` is sampled as the serial clock falls (end of the high half). The 48 bits form word 0, then word 1, then word 2, each sent most significant bit first.
- R7: After completion, `cfg_word` equals word 0, `vend_id` equals word 1 (high byte in bits 15..8), `prod_id` equals word 2, and `gang_mode` equals bit 15 of word 0. Before completion all four outputs are zero.
- R8: `boot_done` is a single-cycle pulse. When the memory is read, it occurs in cycle `58*CLK_DIV` counted from the start of the transfer. The outputs then hold their values.
- R9: After completion, `sck_oe`, `sio_oe`, `sck_o` and `sio_o` are all low until the next reset.
- R10: With `ext_rom_n` high, neither enable is ever raised. `boot_done` pulses in the first cycle after the first post-reset edge. The outputs then show `DEF_CFG`, `DEF_VID` and `DEF_PID`, and `gang_mode` equals bit 15 of `DEF_CFG`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_rom_n | input | 1 | Strap: low reads the EEPROM, high uses built-in defaults |
| sio_i | input | 1 | Data wire as seen at the pad |
| sck_o | output | 1 | Serial clock value |
| sck_oe | output | 1 | Serial clock output enable |
| sio_o | output | 1 | Data wire drive value |
| sio_oe | output | 1 | Data wire output enable |
| cfg_word | output | 16 | Configuration word (word 0) |
| vend_id | output | 16 | Vendor ID (word 1) |
| prod_id | output | 16 | Product ID (word 2) |
| gang_mode | output | 1 | Ganged power handling flag, bit 15 of the configuration word |
| boot_done | output | 1 | One-cycle pulse when the outputs become valid |

## Verification
The assertions assume that the strap is static while reset is high. The bench changes `ext_rom_n` only while `rst_n` is held low. They also assume that the data wire is driven by the memory only after the block has released it. The bench's memory model starts driving only on the rising serial clock edge that follows the block's release, and a bench check flags any overlap of the two drivers. The filler bit is driven as 0 in one run and as 1 in another, so that its value cannot leak into the words.

// File: rtl/mwr_pkg.sv
package mwr_pkg;
  localparam int WORD_W     = 16;
  localparam int N_WORDS    = 3;
  localparam int CMD_BITS   = 9;   // start + 2 opcode + 6 address
  localparam int FILL_BITS  = 1;
  localparam int DATA_BITS  = WORD_W * N_WORDS;
  localparam int FIRST_DATA = CMD_BITS + FILL_BITS;
  localparam int TOTAL      = FIRST_DATA + DATA_BITS;
  localparam int IDX_W      = $clog2(TOTAL);

  typedef enum logic [1:0] {ST_INIT, ST_XFER, ST_FIN} mwr_state_t;

  // Command bit for period idx: start 1, opcode 1 then 0, address all zero.
  function automatic logic cmd_bit(input logic [IDX_W-1:0] idx);
    return idx < IDX_W'(2);
  endfunction

  // Word n of the captured burst (word 0 arrives first).
  function automatic logic [WORD_W-1:0] word_of(input logic [DATA_BITS-1:0] sh,
                                                input int n);
    return sh[DATA_BITS-1-n*WORD_W -: WORD_W];
  endfunction
endpackage

// File: rtl/mwr_sck_gen.sv
module mwr_sck_gen #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sck,
  output logic fall_tk
);
  localparam int CNT_W = $clog2(DIV);
  localparam int HALF  = DIV / 2;

  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap    = cnt_q == CNT_W'(DIV - 1);
  assign fall_tk = run && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck   <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      sck   <= 1'b0;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (cnt_q == CNT_W'(HALF - 1)) sck <= 1'b1;
      else if (wrap)                 sck <= 1'b0;
    end
  end
endmodule

// File: rtl/mwr_shift_in.sv
module mwr_shift_in #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (cap) q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/mwr_boot_reader.sv
module mwr_boot_reader
  import mwr_pkg::*;
#(
  parameter int          CLK_DIV = 64,
  parameter logic [15:0] DEF_CFG = 16'h0000,
  parameter logic [15:0] DEF_VID = 16'hF00D,
  parameter logic [15:0] DEF_PID = 16'h0C0A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ext_rom_n,
  input  logic        sio_i,
  output logic        sck_o,
  output logic        sck_oe,
  output logic        sio_o,
  output logic        sio_oe,
  output logic [15:0] cfg_word,
  output logic [15:0] vend_id,
  output logic [15:0] prod_id,
  output logic        gang_mode,
  output logic        boot_done
);
  mwr_state_t           state_q;
  logic [IDX_W-1:0]     bit_q;
  logic                 use_def_q;
  logic                 done_q;
  logic                 run;
  logic                 fall_evt;
  logic                 last_evt;
  logic                 cap_evt;
  logic                 fin_w;
  logic [DATA_BITS-1:0] sh_q;

  assign run      = state_q == ST_XFER;
  assign fin_w    = state_q == ST_FIN;
  assign last_evt = fall_evt && bit_q == IDX_W'(TOTAL - 1);
  assign cap_evt  = fall_evt && bit_q >= IDX_W'(FIRST_DATA);

  mwr_sck_gen #(.DIV(CLK_DIV)) u_sck (
    .clk(clk), .rst_n(rst_n), .run(run), .sck(sck_o), .fall_tk(fall_evt)
  );

  mwr_shift_in #(.W(DATA_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .cap(cap_evt), .din(sio_i), .q(sh_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_INIT;
      bit_q     <= '0;
      use_def_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_INIT: begin
          use_def_q <= ext_rom_n;
          done_q    <= ext_rom_n;
          state_q   <= ext_rom_n ? ST_FIN : ST_XFER;
        end
        ST_XFER: begin
          if (last_evt) begin
            state_q <= ST_FIN;
            done_q  <= 1'b1;
          end else if (fall_evt) begin
            bit_q <= bit_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign sck_oe    = run;
  assign sio_oe    = run && bit_q < IDX_W'(CMD_BITS);
  assign sio_o     = sio_oe && cmd_bit(bit_q);
  assign boot_done = done_q;

  assign cfg_word  = !fin_w ? '0 : (use_def_q ? DEF_CFG : word_of(sh_q, 0));
  assign vend_id   = !fin_w ? '0 : (use_def_q ? DEF_VID : word_of(sh_q, 1));
  assign prod_id   = !fin_w ? '0 : (use_def_q ? DEF_PID : word_of(sh_q, 2));
  assign gang_mode = cfg_word[15];
endmodule

// File: rtl/mwr_boot_chk.sv
module mwr_boot_chk
  import mwr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ext_rom_n,
  input logic             sck_o,
  input logic             sck_oe,
  input logic             sio_o,
  input logic             sio_oe,
  input logic             boot_done,
  input logic             fin_w,
  input logic [IDX_W-1:0] bit_idx
);
  // R1
  end_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck_oe) |-> boot_done);

  // R2
  sck_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck_o |-> sck_oe);

  // R3
  sio_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_o && $past(sck_o)) |-> $stable(sio_o));

  // R4
  release_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sio_oe) |-> bit_idx == IDX_W'(CMD_BITS));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> !boot_done);

  // R9
  bus_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_w |-> (!sck_oe && !sio_oe && !sck_o && !sio_o));

  // R10
  strap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rom_n |-> (!sck_oe && !sio_oe));
endmodule

bind mwr_boot_reader mwr_boot_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ext_rom_n(ext_rom_n),
  .sck_o(sck_o), .sck_oe(sck_oe), .sio_o(sio_o), .sio_oe(sio_oe),
  .boot_done(boot_done), .fin_w(fin_w), .bit_idx(bit_q)
);

// File: tb/sim_mwr_boot_reader.sv
module sim_mwr_boot_reader;
  localparam int DIV  = 8;
  localparam int TOT  = 58 * DIV;
  localparam logic [15:0] DC = 16'h9C01, DV = 16'hBEEF, DP = 16'h4321;

  logic clk = 1'b0, rst_n = 1'b0, strap = 1'b0;
  logic sck_o, sck_oe, sio_o, sio_oe, gang_mode, boot_done, sio_i;
  logic [15:0] cfg_word, vend_id, prod_id;

  int checks = 0, errors = 0, cyc = 0;

  // EEPROM model state
  int          rcnt = 0;
  logic [8:0]  cmd_cap = '0;
  logic [47:0] mem_data = '0;
  logic        fill_val = 1'b0, mem_oe = 1'b0, mem_bit = 1'b0;

  always #10 clk = ~clk;

  assign sio_i = sio_oe ? sio_o : (mem_oe ? mem_bit : 1'b0);

  mwr_boot_reader #(.CLK_DIV(DIV), .DEF_CFG(DC), .DEF_VID(DV), .DEF_PID(DP)) u0 (
    .clk(clk), .rst_n(rst_n), .ext_rom_n(strap), .sio_i(sio_i),
    .sck_o(sck_o), .sck_oe(sck_oe), .sio_o(sio_o), .sio_oe(sio_oe),
    .cfg_word(cfg_word), .vend_id(vend_id), .prod_id(prod_id),
    .gang_mode(gang_mode), .boot_done(boot_done)
  );

  // Memory: samples command on rising edges, updates its output on rising edges.
  always @(posedge sck_o) begin
    if (rcnt < 9) cmd_cap[8 - rcnt] = sio_o;
    rcnt = rcnt + 1;
    if (rcnt == 10) begin
      mem_oe  = 1'b1;
      mem_bit = fill_val;
    end else if (rcnt >= 11 && rcnt <= 58) begin
      mem_bit = mem_data[47 - (rcnt - 11)];
    end else begin
      mem_bit = 1'b0;
    end
  end
  always @(negedge sck_oe) mem_oe = 1'b0;

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog act=%0d exp=<20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_boot(input logic s, input logic [15:0] w0, w1, w2, input logic fv);
    logic [15:0] e0, e1, e2;
    rst_n = 1'b0; strap = s; rcnt = 0; cmd_cap = '0; mem_oe = 1'b0; mem_bit = 1'b0;
    mem_data = {w0, w1, w2}; fill_val = fv;
    repeat (3) @(negedge clk);
    chk("R1 reset sck_oe", 48'(sck_oe), 48'd0);
    chk("R7 reset words", {cfg_word, vend_id, prod_id}, 48'd0);
    chk("R8 reset done", 48'(boot_done), 48'd0);
    rst_n = 1'b1;
    e0 = s ? DC : w0; e1 = s ? DV : w1; e2 = s ? DP : w2;
    for (int e = 1; e <= TOT + 20; e++) begin
      int k, p;
      logic x_sck, x_sckoe, x_sio, x_siooe, x_done, x_fin;
      @(negedge clk);
      k = e - 1; p = k / DIV;
      if (s) begin
        x_sckoe = 0; x_sck = 0; x_siooe = 0; x_sio = 0;
        x_done = (k == 0); x_fin = 1;
      end else begin
        x_sckoe = (k < TOT);
        x_sck   = x_sckoe && ((k % DIV) >= DIV / 2);
        x_siooe = x_sckoe && (p < 9);
        x_sio   = x_siooe && (p < 2);
        x_done  = (k == TOT);
        x_fin   = (k >= TOT);
      end
      chk(s ? "R10 sck_oe" : (x_fin ? "R9 sck_oe" : "R2 sck_oe"), 48'(sck_oe), 48'(x_sckoe));
      chk(s ? "R10 sck" : (x_fin ? "R1 sck after end" : "R2 sck shape"), 48'(sck_o), 48'(x_sck));
      chk(x_fin ? "R9 sio_oe" : "R4 sio_oe", 48'(sio_oe), 48'(x_siooe));
      chk(x_fin ? "R9 sio" : "R3 sio cmd", 48'(sio_o), 48'(x_sio));
      chk(s ? "R10 done" : "R8 done", 48'(boot_done), 48'(x_done));
      if (sio_oe && mem_oe) chk("R4 contention", 48'd1, 48'd0);
      if (x_fin) begin
        chk(s ? "R10 cfg" : "R7 cfg", 48'(cfg_word), 48'(e0));
        chk(s ? "R10 vid" : "R6 vid", 48'(vend_id), 48'(e1));
        chk(s ? "R10 pid" : "R6 pid", 48'(prod_id), 48'(e2));
        chk("R7 gang", 48'(gang_mode), 48'(e0[15]));
      end else begin
        chk("R7 words zero", {cfg_word, vend_id, prod_id}, 48'd0);
      end
    end
    chk(s ? "R10 no clock edges" : "R1 clock edge count", 48'(rcnt), s ? 48'd0 : 48'd58);
    if (!s) chk("R3 captured command", 48'(cmd_cap), 48'h180);
  endtask

  initial begin
    run_boot(1'b0, 16'h8001, 16'hA55A, 16'h1234, 1'b0);  // R6 R7 gang set
    run_boot(1'b0, 16'h7FFE, 16'hFFFF, 16'h0000, 1'b1);  // R5 filler 1 discarded
    run_boot(1'b1, 16'h1111, 16'h2222, 16'h3333, 1'b0);  // R10 strap high
    run_boot(1'b0, 16'h0F0F, 16'h00FF, 16'hC3C3, 1'b0);  // R1 fresh read after reset
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule